// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This block joins two eight-line priority controllers into one sixteen-line interrupt source. One is the primary and one is the secondary. Global request lines 0 to 7 feed the primary and lines 8 to 15 feed the secondary. The secondary's resolved request drives primary line 2, so a CPU sees one request pin and one acknowledge path.

The CPU takes an interrupt in one of two ways:
- **Acknowledge strobe.** The unit returns an 8-bit vector in the same cycle as the strobe. It substitutes line 7 when no real request is present.
- **Polled read.** The unit returns a line number rather than a vector, retires the line on the spot, and switches the status select to the in-service view.

Each controller also takes a non-specific end-of-interrupt strobe. Requests can be edge or level sensitive, but only on the lines that allow level mode. Per-line masking comes from plain control inputs.

The acknowledge and poll strobes are one-cycle, fire-and-forget events. There is no ready signal and no back-pressure. `vec_o` and `poll_o` are valid only in the cycle their strobe is high. Every strobe is consumed at the next rising edge. If both strobes are high together, the acknowledge is served and the poll is dropped.

Top module: `casc_ack_unit`

## Requirements
- R1: Bit 3 of a global line number picks the controller (0 = primary, 1 = secondary), and bits 2:0 give the local line. A vector is the upper five bits of that controller's base input with the local line in bits 2:0. The base's low three bits are ignored.
- R2: Within a controller, the lowest-numbered unmasked pending line wins. It wins only if its number is strictly lower than every in-service line of that controller.
- R3: An acknowledge with a primary winner other than line 2 does three things: it returns the primary vector for that line, sets that line's in-service bit, and clears its request bit.
- R4: An acknowledge whose primary winner is line 2 also acknowledges the secondary. It returns the secondary vector of the secondary winner and sets that winner's in-service bit, as well as primary in-service bit 2.
- R5: If the primary has no winner, an acknowledge returns primary vector line 7. If a cascade acknowledge finds no secondary winner, it returns secondary vector line 7. In both cases the substituted line 7 gets no in-service bit.
- R6: Whenever the secondary has a winner, primary request bit 2 is set and latched. `cpu_int_o` is high exactly when the primary has a winner, re-evaluated in every cycle including the one after an acknowledge.
- R7: A poll returns the primary winner's line number (0 to 7) and clears both its request and in-service bits. With no winner, a poll returns 7.
- R8: When a poll's primary winner is line 2, the result is 8 plus the secondary winner, or 15 if there is none. The secondary winner's request and in-service bits are cleared, and so are primary bits 2. Any poll sets `rd_isr_sel_o` from the next cycle on.
- R9: Level mode can be selected only on primary lines 3 to 7 and secondary local lines 1, 2, 3, 4, 6 and 7. The capable-line masks are 0xF8 and 0xDE. All other lines stay edge sensitive whatever `trig_lvl_i` says.
- R10: A level-sensitive request bit follows its line, so a line that drops before being served leaves nothing pending.
- R11: An edge-sensitive request is latched on a rising edge and stays pending after the line falls. A line held high raises no new request once served.
- R12: A line whose `imr_i` bit is 1 cannot win and cannot raise `cpu_int_o`. Its latched request comes back into play when the mask is removed.
- R13: An end-of-interrupt strobe clears the lowest-numbered in-service bit of its controller.
- R14: Global line 2 is not a request input: primary line 2 is driven only by the cascade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 16 | Global request lines |
| trig_lvl_i | input | 16 | Per-line level select (1 = level) |
| imr_i | input | 16 | Per-line mask (1 = masked) |
| base_m_i | input | 8 | Primary vector base (bits 7:3 used) |
| base_s_i | input | 8 | Secondary vector base (bits 7:3 used) |
| ack_i | input | 1 | CPU acknowledge strobe |
| poll_i | input | 1 | Polled acknowledge strobe |
| eoi_m_i | input | 1 | Primary end-of-interrupt strobe |
| eoi_s_i | input | 1 | Secondary end-of-interrupt strobe |
| cpu_int_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Vector, valid with ack_i |
| poll_o | output | 8 | Polled line number, valid with poll_i |
| rd_isr_sel_o | output | 1 | Status view select, set by a poll |

## Verification
Directed sequences separate the paths:
- single primary and secondary lines tell routing and base handling apart;
- simultaneous lines at different numbers tell priority from in-service blocking;
- a secondary level pulse that vanishes before the acknowledge exposes the secondary spurious path, distinct from the primary one;
- held, dropped and re-raised lines tell edge latching from level following on capable and non-capable lines.

Random stretches then mix line toggles, masks, trigger selections, bases, acknowledges, polls and end-of-interrupt strobes. They catch interactions such as nested in-service blocking across the cascade and a poll retiring primary line 2.

// File: rtl/casc_ack_pkg.sv
package casc_ack_pkg;
  localparam int LOC_LINES = 8;
  localparam int CASC_LINE = 2;
  localparam int SPUR_LINE = 7;
  localparam logic [7:0] LVL_OK_MASTER = 8'hF8;
  localparam logic [7:0] LVL_OK_SLAVE  = 8'hDE;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_ACK  = 2'd1,
    ACT_POLL = 2'd2
  } act_e;
endpackage

// File: rtl/casc_pri_pick.sv
module casc_pri_pick #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] isr_i,
  output logic         vld_o,
  output logic [W-1:0] idx_o
);
  logic         req_any;
  logic         isr_any;
  logic [W-1:0] req_idx;
  logic [W-1:0] isr_idx;

  // Lowest index is highest priority; scan downward so the lowest set bit sticks.
  always_comb begin
    req_any = 1'b0;
    isr_any = 1'b0;
    req_idx = '0;
    isr_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        req_any = 1'b1;
        req_idx = W'(i);
      end
      if (isr_i[i]) begin
        isr_any = 1'b1;
        isr_idx = W'(i);
      end
    end
  end

  assign vld_o = req_any && (!isr_any || (req_idx < isr_idx));
  assign idx_o = req_idx;
endmodule

// File: rtl/casc_irq_bank.sv
module casc_irq_bank #(
  parameter int           N      = 8,
  parameter int           W      = $clog2(N),
  parameter logic [N-1:0] LVL_OK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] lvl_sel_i,
  input  logic [N-1:0] imr_i,
  input  logic [N-1:0] inj_i,
  input  logic [N-1:0] clr_irr_i,
  input  logic [N-1:0] clr_isr_i,
  input  logic [N-1:0] set_isr_i,
  input  logic         eoi_i,
  output logic [N-1:0] isr_o,
  output logic         win_vld_o,
  output logic [W-1:0] win_idx_o
);
  logic [N-1:0] irr_q, isr_q, last_q;
  logic [N-1:0] irr_eff, rise, lvl, eoi_bit;
  logic [N-1:0] irr_d, isr_d;

  assign lvl     = lvl_sel_i & LVL_OK;
  assign rise    = line_i & ~last_q;
  // Injected bits take part in this cycle's resolution and are latched as edges.
  assign irr_eff = irr_q | inj_i;
  assign eoi_bit = eoi_i ? (isr_q & (~isr_q + N'(1))) : '0;

  always_comb begin
    irr_d = (irr_eff & ~clr_irr_i) | rise;
    irr_d = (irr_d & ~lvl) | (line_i & lvl);
    isr_d = (isr_q & ~clr_isr_i & ~eoi_bit) | set_isr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      isr_q  <= '0;
      last_q <= '0;
    end else begin
      irr_q  <= irr_d;
      isr_q  <= isr_d;
      last_q <= line_i;
    end
  end

  casc_pri_pick #(.N(N), .W(W)) u_pick (
    .req_i (irr_eff & ~imr_i),
    .isr_i (isr_q),
    .vld_o (win_vld_o),
    .idx_o (win_idx_o)
  );

  assign isr_o = isr_q;
endmodule

// File: rtl/casc_ack_seq.sv
module casc_ack_seq
  import casc_ack_pkg::*;
#(
  parameter int N     = 8,
  parameter int W     = $clog2(N),
  parameter int VEC_W = 8,
  parameter int CASC  = 2,
  parameter int SPUR  = 7
) (
  input  logic             ack_i,
  input  logic             poll_i,
  input  logic             m_vld_i,
  input  logic [W-1:0]     m_idx_i,
  input  logic             s_vld_i,
  input  logic [W-1:0]     s_idx_i,
  input  logic [VEC_W-W-1:0] base_m_hi_i,
  input  logic [VEC_W-W-1:0] base_s_hi_i,
  output logic [N-1:0]     m_clr_irr_o,
  output logic [N-1:0]     m_clr_isr_o,
  output logic [N-1:0]     m_set_isr_o,
  output logic [N-1:0]     s_clr_irr_o,
  output logic [N-1:0]     s_clr_isr_o,
  output logic [N-1:0]     s_set_isr_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [VEC_W-1:0] poll_o
);
  localparam logic [N-1:0] CASC_BIT = N'(1) << CASC;

  act_e         act;
  logic         casc;
  logic [W-1:0] m_line, s_line;
  logic [N-1:0] m_sel, s_sel;

  assign act    = ack_i ? ACT_ACK : (poll_i ? ACT_POLL : ACT_NONE);
  assign casc   = m_vld_i && (m_idx_i == W'(CASC));
  assign m_line = m_vld_i ? m_idx_i : W'(SPUR);
  assign s_line = s_vld_i ? s_idx_i : W'(SPUR);
  assign m_sel  = m_vld_i ? (N'(1) << m_idx_i) : '0;
  assign s_sel  = (casc && s_vld_i) ? (N'(1) << s_idx_i) : '0;

  assign vec_o  = casc ? {base_s_hi_i, s_line} : {base_m_hi_i, m_line};
  assign poll_o = casc ? (VEC_W'(N) + VEC_W'(s_line)) : VEC_W'(m_line);

  always_comb begin
    m_clr_irr_o = '0;
    m_clr_isr_o = '0;
    m_set_isr_o = '0;
    s_clr_irr_o = '0;
    s_clr_isr_o = '0;
    s_set_isr_o = '0;
    unique case (act)
      ACT_ACK: begin
        m_clr_irr_o = m_sel;
        m_set_isr_o = m_sel;
        s_clr_irr_o = s_sel;
        s_set_isr_o = s_sel;
      end
      ACT_POLL: begin
        // A secondary poll also retires the primary cascade bit.
        m_clr_irr_o = m_sel | (casc ? CASC_BIT : '0);
        m_clr_isr_o = m_sel | (casc ? CASC_BIT : '0);
        s_clr_irr_o = s_sel;
        s_clr_isr_o = s_sel;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/casc_ack_unit.sv
module casc_ack_unit
  import casc_ack_pkg::*;
#(
  parameter int               N_LOC    = LOC_LINES,
  parameter int               VEC_W    = 8,
  parameter int               CASC     = CASC_LINE,
  parameter int               SPUR     = SPUR_LINE,
  parameter logic [N_LOC-1:0] LVL_OK_M = LVL_OK_MASTER,
  parameter logic [N_LOC-1:0] LVL_OK_S = LVL_OK_SLAVE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2*N_LOC-1:0] irq_i,
  input  logic [2*N_LOC-1:0] trig_lvl_i,
  input  logic [2*N_LOC-1:0] imr_i,
  input  logic [VEC_W-1:0]   base_m_i,
  input  logic [VEC_W-1:0]   base_s_i,
  input  logic               ack_i,
  input  logic               poll_i,
  input  logic               eoi_m_i,
  input  logic               eoi_s_i,
  output logic               cpu_int_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [VEC_W-1:0]   poll_o,
  output logic               rd_isr_sel_o
);
  localparam int W     = $clog2(N_LOC);
  localparam int N_ALL = 2 * N_LOC;

  logic [N_LOC-1:0] m_line, s_line, m_lvl, s_lvl, m_imr, s_imr;
  logic [N_LOC-1:0] m_inj, s_inj;
  logic [N_LOC-1:0] m_clr_irr, m_clr_isr, m_set_isr;
  logic [N_LOC-1:0] s_clr_irr, s_clr_isr, s_set_isr;
  logic [N_LOC-1:0] m_isr, s_isr;
  logic             m_vld, s_vld;
  logic [W-1:0]     m_idx, s_idx;
  logic             sel_q;
  logic [2*W:0]     unused_bits;

  // Global line g goes to controller g / N_LOC, local line g % N_LOC.
  for (genvar g = 0; g < N_ALL; g++) begin : g_route
    if (g < N_LOC) begin : g_pri
      if (g == CASC) begin : g_casc
        assign m_line[g] = 1'b0;
      end else begin : g_norm
        assign m_line[g] = irq_i[g];
      end
      assign m_lvl[g] = trig_lvl_i[g];
      assign m_imr[g] = imr_i[g];
    end else begin : g_sec
      assign s_line[g-N_LOC] = irq_i[g];
      assign s_lvl[g-N_LOC]  = trig_lvl_i[g];
      assign s_imr[g-N_LOC]  = imr_i[g];
    end
  end

  assign unused_bits = {irq_i[CASC], base_m_i[W-1:0], base_s_i[W-1:0]};

  // The secondary is resolved first; its winner pulses primary line 2.
  assign s_inj = '0;
  assign m_inj = s_vld ? (N_LOC'(1) << CASC) : '0;

  casc_irq_bank #(.N(N_LOC), .W(W), .LVL_OK(LVL_OK_S)) u_sec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (s_line),
    .lvl_sel_i (s_lvl),
    .imr_i     (s_imr),
    .inj_i     (s_inj),
    .clr_irr_i (s_clr_irr),
    .clr_isr_i (s_clr_isr),
    .set_isr_i (s_set_isr),
    .eoi_i     (eoi_s_i),
    .isr_o     (s_isr),
    .win_vld_o (s_vld),
    .win_idx_o (s_idx)
  );

  casc_irq_bank #(.N(N_LOC), .W(W), .LVL_OK(LVL_OK_M)) u_pri (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (m_line),
    .lvl_sel_i (m_lvl),
    .imr_i     (m_imr),
    .inj_i     (m_inj),
    .clr_irr_i (m_clr_irr),
    .clr_isr_i (m_clr_isr),
    .set_isr_i (m_set_isr),
    .eoi_i     (eoi_m_i),
    .isr_o     (m_isr),
    .win_vld_o (m_vld),
    .win_idx_o (m_idx)
  );

  casc_ack_seq #(.N(N_LOC), .W(W), .VEC_W(VEC_W), .CASC(CASC), .SPUR(SPUR)) u_seq (
    .ack_i       (ack_i),
    .poll_i      (poll_i),
    .m_vld_i     (m_vld),
    .m_idx_i     (m_idx),
    .s_vld_i     (s_vld),
    .s_idx_i     (s_idx),
    .base_m_hi_i (base_m_i[VEC_W-1:W]),
    .base_s_hi_i (base_s_i[VEC_W-1:W]),
    .m_clr_irr_o (m_clr_irr),
    .m_clr_isr_o (m_clr_isr),
    .m_set_isr_o (m_set_isr),
    .s_clr_irr_o (s_clr_irr),
    .s_clr_isr_o (s_clr_isr),
    .s_set_isr_o (s_set_isr),
    .vec_o       (vec_o),
    .poll_o      (poll_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else if (poll_i && !ack_i) sel_q <= 1'b1;
  end

  assign cpu_int_o    = m_vld;
  assign rd_isr_sel_o = sel_q;
endmodule

// File: rtl/casc_ack_chk.sv
module casc_ack_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ack_i,
  input logic        poll_i,
  input logic        eoi_m_i,
  input logic [15:0] imr_i,
  input logic [7:0]  base_m_i,
  input logic        cpu_int_o,
  input logic [7:0]  vec_o,
  input logic [7:0]  poll_o,
  input logic        rd_isr_sel_o,
  input logic        m_vld,
  input logic [2:0]  m_idx,
  input logic        s_vld,
  input logic [2:0]  s_idx,
  input logic [7:0]  m_isr,
  input logic [7:0]  s_isr
);
  logic [7:0] m_sel, s_sel;
  assign m_sel = 8'(1) << m_idx;
  assign s_sel = 8'(1) << s_idx;

  p_ack_isr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && m_vld |=> (m_isr & $past(m_sel)) == $past(m_sel));

  p_casc_isr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && m_vld && m_idx == 3'd2 && s_vld |=> (s_isr & $past(s_sel)) == $past(s_sel));

  p_spur_vec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !m_vld |-> vec_o == {base_m_i[7:3], 3'd7});

  p_casc_int_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_vld && m_isr == 8'd0 && !imr_i[2] |-> cpu_int_o);

  p_poll_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_i && !ack_i && m_vld && m_idx != 3'd2 |=> (m_isr & $past(m_sel)) == 8'd0);

  p_poll_none_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_i && !m_vld |-> poll_o == 8'd7);

  p_isr_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_i && !ack_i |=> rd_isr_sel_o);

  p_eoi_one_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_m_i && !ack_i && !poll_i && m_isr != 8'd0
    |=> $countones(m_isr) + 1 == $countones($past(m_isr)));
endmodule

bind casc_ack_unit casc_ack_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ack_i        (ack_i),
  .poll_i       (poll_i),
  .eoi_m_i      (eoi_m_i),
  .imr_i        (imr_i),
  .base_m_i     (base_m_i),
  .cpu_int_o    (cpu_int_o),
  .vec_o        (vec_o),
  .poll_o       (poll_o),
  .rd_isr_sel_o (rd_isr_sel_o),
  .m_vld        (m_vld),
  .m_idx        (m_idx),
  .s_vld        (s_vld),
  .s_idx        (s_idx),
  .m_isr        (m_isr),
  .s_isr        (s_isr)
);

// File: tb/casc_ack_unit_tb_top.sv
module casc_ack_unit_tb_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0, trig = '0, imr = '0;
  logic [7:0]  bm = 8'h43, bs = 8'h75;
  logic        ack = 1'b0, poll = 1'b0, em = 1'b0, es = 1'b0;
  logic        cpu_int, isel;
  logic [7:0]  vec, pol;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit [7:0] irr_m [2];
  bit [7:0] isr_m [2];
  bit [7:0] last_m [2];
  bit       sel_m;
  logic [7:0] got_vec, got_poll;
  logic       got_int;

  always #(CLK_NS/2) clk = ~clk;

  casc_ack_unit dut_i (
    .clk_i (clk), .rst_ni (rst_n), .irq_i (irq), .trig_lvl_i (trig), .imr_i (imr),
    .base_m_i (bm), .base_s_i (bs), .ack_i (ack), .poll_i (poll),
    .eoi_m_i (em), .eoi_s_i (es), .cpu_int_o (cpu_int), .vec_o (vec),
    .poll_o (pol), .rd_isr_sel_o (isel)
  );

  function automatic int pick(bit [7:0] req, bit [7:0] in_svc);
    int r = -1;
    int s = 8;
    for (int i = 7; i >= 0; i--) begin
      if (req[i]) r = i;
      if (in_svc[i]) s = i;
    end
    if (r >= 0 && r < s) return r;
    return -1;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic cyc(bit [15:0] l, bit a, bit p, bit e_m, bit e_s, string tag);
    bit [7:0] ln [2];
    bit [7:0] lvl [2];
    bit [7:0] ci [2];
    bit [7:0] cs [2];
    bit [7:0] ss [2];
    bit [7:0] inj, ev, ep, r, eb;
    int sw, mw;
    string tv, tp;
    irq = l; ack = a; poll = p; em = e_m; es = e_s;
    #1;
    sw  = pick(irr_m[1] & ~imr[15:8], isr_m[1]);
    inj = (sw >= 0) ? 8'h04 : 8'h00;
    mw  = pick((irr_m[0] | inj) & ~imr[7:0], isr_m[0]);
    for (int b = 0; b < 2; b++) begin ci[b] = 0; cs[b] = 0; ss[b] = 0; end
    if (mw < 0) begin
      ev = {bm[7:3], 3'd7}; ep = 8'd7; tv = "R5"; tp = "R7";
    end else if (mw == 2) begin
      tp = "R8";
      if (sw >= 0) begin ev = {bs[7:3], 3'(sw)}; ep = 8'(8 + sw); tv = "R4"; end
      else begin ev = {bs[7:3], 3'd7}; ep = 8'd15; tv = "R5"; end
    end else begin
      ev = {bm[7:3], 3'(mw)}; ep = 8'(mw); tv = "R3"; tp = "R7";
    end
    if (tag != "") begin tv = tag; tp = tag; end
    got_int = cpu_int; got_vec = vec; got_poll = pol;
    chk((tag != "") ? tag : "R6", {7'd0, cpu_int}, {7'd0, (mw >= 0)});
    chk((tag != "") ? tag : "R8", {7'd0, isel}, {7'd0, sel_m});
    if (a) chk(tv, vec, ev);
    if (p) chk(tp, pol, ep);
    if (a && mw >= 0) begin
      ci[0][mw] = 1; ss[0][mw] = 1;
      if (mw == 2 && sw >= 0) begin ci[1][sw] = 1; ss[1][sw] = 1; end
    end else if (p && mw >= 0) begin
      ci[0][mw] = 1; cs[0][mw] = 1;
      if (mw == 2 && sw >= 0) begin ci[1][sw] = 1; cs[1][sw] = 1; end
    end
    ln[0]  = {l[7:3], 1'b0, l[1:0]};
    ln[1]  = l[15:8];
    lvl[0] = trig[7:0] & 8'hF8;
    lvl[1] = trig[15:8] & 8'hDE;
    for (int b = 0; b < 2; b++) begin
      r = ((irr_m[b] | ((b == 0) ? inj : 8'h00)) & ~ci[b]) | (ln[b] & ~last_m[b]);
      irr_m[b] = (r & ~lvl[b]) | (ln[b] & lvl[b]);
      eb = isr_m[b] & (~isr_m[b] + 8'd1);
      if (!((b == 0) ? e_m : e_s)) eb = 0;
      isr_m[b] = (isr_m[b] & ~cs[b] & ~eb) | ss[b];
      last_m[b] = ln[b];
    end
    if (p && !a) sel_m = 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit [15:0] cur;
    void'($urandom(32'd4242));
    for (int b = 0; b < 2; b++) begin irr_m[b] = 0; isr_m[b] = 0; last_m[b] = 0; end
    sel_m = 0;
    repeat (3) @(negedge clk);
    chk("R6", {7'd0, cpu_int}, 8'd0);
    chk("R8", {7'd0, isel}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: routing and base handling
    cyc(16'h0020, 0, 0, 0, 0, "R1");
    cyc(16'h0020, 1, 0, 0, 0, "R1"); chk("R1", got_vec, 8'h45);
    cyc(16'h0000, 0, 0, 1, 0, "R13");
    cyc(16'h1000, 0, 0, 0, 0, "R1");
    cyc(16'h1000, 1, 0, 0, 0, "R4"); chk("R4", got_vec, 8'h74);
    cyc(16'h0000, 0, 0, 1, 1, "R13");

    // R2: priority and in-service blocking
    cyc(16'h0048, 0, 0, 0, 0, "R2");
    cyc(16'h0048, 1, 0, 0, 0, "R2"); chk("R2", got_vec, 8'h43);
    cyc(16'h0048, 0, 0, 0, 0, "R2"); chk("R2", {7'd0, got_int}, 8'd0);
    cyc(16'h0048, 1, 0, 0, 0, "R5"); chk("R5", got_vec, 8'h47);
    cyc(16'h0048, 0, 0, 1, 0, "R13");
    cyc(16'h0048, 1, 0, 0, 0, "R2"); chk("R2", got_vec, 8'h46);
    cyc(16'h0000, 0, 0, 1, 0, "R13");

    // R14: global line 2 ignored
    cyc(16'h0004, 0, 0, 0, 0, "R14");
    cyc(16'h0004, 0, 0, 0, 0, "R14"); chk("R14", {7'd0, got_int}, 8'd0);
    cyc(16'h0004, 1, 0, 0, 0, "R14"); chk("R14", got_vec, 8'h47);
    cyc(16'h0000, 0, 0, 0, 0, "R14");

    // R12: masking, then R11: held edge line
    imr = 16'h0010;
    cyc(16'h0010, 0, 0, 0, 0, "R12");
    cyc(16'h0010, 0, 0, 0, 0, "R12"); chk("R12", {7'd0, got_int}, 8'd0);
    imr = 16'h0000;
    cyc(16'h0010, 0, 0, 0, 0, "R12"); chk("R12", {7'd0, got_int}, 8'd1);
    cyc(16'h0010, 1, 0, 0, 0, "R12"); chk("R12", got_vec, 8'h44);
    cyc(16'h0010, 0, 0, 1, 0, "R13");
    cyc(16'h0010, 0, 0, 0, 0, "R11"); chk("R11", {7'd0, got_int}, 8'd0);
    cyc(16'h0000, 0, 0, 0, 0, "R11");
    cyc(16'h0010, 0, 0, 0, 0, "R11");
    cyc(16'h0010, 0, 0, 0, 0, "R11"); chk("R11", {7'd0, got_int}, 8'd1);
    cyc(16'h0010, 1, 0, 0, 0, "R11");
    cyc(16'h0000, 0, 0, 1, 0, "R13");
    cyc(16'h0040, 0, 0, 0, 0, "R11");
    cyc(16'h0000, 0, 0, 0, 0, "R11");
    cyc(16'h0000, 0, 0, 0, 0, "R11"); chk("R11", {7'd0, got_int}, 8'd1);
    cyc(16'h0000, 1, 0, 0, 0, "R11"); chk("R11", got_vec, 8'h46);
    cyc(16'h0000, 0, 0, 1, 0, "R13");

    // R10: level line follows its input
    trig = 16'h0010;
    cyc(16'h0010, 0, 0, 0, 0, "R10");
    cyc(16'h0010, 0, 0, 0, 0, "R10"); chk("R10", {7'd0, got_int}, 8'd1);
    cyc(16'h0000, 0, 0, 0, 0, "R10");
    cyc(16'h0000, 0, 0, 0, 0, "R10"); chk("R10", {7'd0, got_int}, 8'd0);

    // R9: level select ignored on non-capable lines
    trig = 16'h0002;
    cyc(16'h0002, 0, 0, 0, 0, "R9");
    cyc(16'h0000, 0, 0, 0, 0, "R9");
    cyc(16'h0000, 0, 0, 0, 0, "R9"); chk("R9", {7'd0, got_int}, 8'd1);
    cyc(16'h0000, 1, 0, 0, 0, "R9"); chk("R9", got_vec, 8'h41);
    cyc(16'h0000, 0, 0, 1, 0, "R13");
    trig = 16'h2000;
    cyc(16'h2000, 0, 0, 0, 0, "R9");
    cyc(16'h0000, 0, 0, 0, 0, "R9");
    cyc(16'h0000, 0, 0, 0, 0, "R9"); chk("R9", {7'd0, got_int}, 8'd1);
    cyc(16'h0000, 1, 0, 0, 0, "R9"); chk("R9", got_vec, 8'h75);
    cyc(16'h0000, 0, 0, 1, 1, "R13");

    // R5: secondary spurious after a vanished level request
    trig = 16'h0200;
    cyc(16'h0200, 0, 0, 0, 0, "R5");
    cyc(16'h0200, 0, 0, 0, 0, "R5");
    cyc(16'h0000, 0, 0, 0, 0, "R5");
    cyc(16'h0000, 0, 0, 0, 0, "R5"); chk("R5", {7'd0, got_int}, 8'd1);
    cyc(16'h0000, 1, 0, 0, 0, "R5"); chk("R5", got_vec, 8'h77);
    cyc(16'h0000, 0, 0, 1, 0, "R13");
    trig = 16'h0000;

    // R7, R8: polled reads
    cyc(16'h0800, 0, 0, 0, 0, "R8");
    cyc(16'h0800, 0, 1, 0, 0, "R8"); chk("R8", got_poll, 8'd11);
    cyc(16'h0000, 0, 1, 0, 0, "R7"); chk("R7", got_poll, 8'd7);
    cyc(16'h0020, 0, 0, 0, 0, "R7");
    cyc(16'h0020, 0, 1, 0, 0, "R7"); chk("R7", got_poll, 8'd5);
    cyc(16'h0020, 0, 0, 0, 0, "R7"); chk("R7", {7'd0, got_int}, 8'd0);
    cyc(16'h0000, 0, 0, 0, 0, "R7");

    // R13: end of interrupt retires the lowest in-service line
    cyc(16'h0008, 0, 0, 0, 0, "R13");
    cyc(16'h0008, 1, 0, 0, 0, "R13"); chk("R13", got_vec, 8'h43);
    cyc(16'h000A, 0, 0, 0, 0, "R13");
    cyc(16'h000A, 1, 0, 0, 0, "R13"); chk("R13", got_vec, 8'h41);
    cyc(16'h000A, 0, 0, 1, 0, "R13");
    cyc(16'h002A, 0, 0, 0, 0, "R13");
    cyc(16'h002A, 0, 0, 0, 0, "R13"); chk("R13", {7'd0, got_int}, 8'd0);
    cyc(16'h002A, 0, 0, 1, 0, "R13");
    cyc(16'h002A, 0, 0, 0, 0, "R13"); chk("R13", {7'd0, got_int}, 8'd1);
    cyc(16'h002A, 1, 0, 0, 0, "R13"); chk("R13", got_vec, 8'h45);
    cyc(16'h0000, 0, 0, 1, 0, "R13");

    // Random mix against the bench model
    cur = 16'h0000;
    for (int blk = 0; blk < 6; blk++) begin
      trig = 16'($urandom);
      imr  = 16'($urandom & $urandom & $urandom);
      bm   = 8'($urandom);
      bs   = 8'($urandom);
      for (int n = 0; n < 600; n++) begin
        int r;
        cur = cur ^ 16'($urandom & $urandom & $urandom);
        r = int'($urandom % 16);
        cyc(cur, r < 2, r == 2, ($urandom % 5) == 0, ($urandom % 5) == 0, "");
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule